// File: doc/BRIEF.md
# HDB3 Line Transmit Encoder with Alarm Fill and Line Loopback

The block turns a serial NRZ bit stream into the two rails of a bipolar line signal. It applies the rule in which runs of four zeros are replaced by patterns that contain a deliberate bipolar violation. Two terminal-side bit ports share the encoder, and a select pin picks one of them. Every bit is a valid/ready transfer, sampled on the rising edge of the transmit clock. The unselected port has ready held low. Both ports also see ready low while line loopback is active, so a source must hold its bit until ready returns. Apart from that, the selected port is never stalled. The line side has no ready: one rail symbol leaves, marked by `line_valid`, for every bit accepted once the look-ahead window is full.

An active-low alarm input makes the encoder treat every accepted bit as a one, so the line carries alternating marks. An active-low line-loopback input sends the recovered receive rails to the line output one clock later. While it is active, the encoder state is frozen and the terminal ports are blocked. A terminal-loopback input matters here only for one reason: holding it low together with line loopback is illegal. That combination raises an error flag and silences the line.

Top module: `hdb3_tx_top`

## Requirements
- R1: With `sel_p1` high only port 1 is ready, and with it low only port 2 is ready; the other port's valid and data have no effect on the line output. Both readies are low while `lb_line_n` is low.
- R2: The window holds four bits. The rail symbol for the k-th bit accepted after reset appears, with `line_valid` high, in the cycle after the clock edge that accepts bit k+4. The first four accepted bits therefore produce no output.
- R3: Mark polarity is encoded as `line_pos`=1 for positive and `line_neg`=1 for negative. A one (mark) has the opposite polarity to the previous pulse, and the first pulse after reset is positive.
- R4: Each four-zero run is replaced by one of two patterns. If the number of non-violation pulses sent since the last violation is odd, the run becomes 000V. If it is even, the run becomes B00V. The count counts as odd after reset. V repeats the polarity of the pulse just before it, and B alternates like a mark.
- R5: The encoded stream never holds more than three zero periods in a row and never three pulses of the same polarity in a row.
- R6: While `ais_n` is low, every accepted bit is encoded as a one, whatever its data value.
- R7: While `lb_line_n` is low and `lb_term_n` is high, each cycle's `rx_valid`/`rx_pos`/`rx_neg` appear on the line outputs one cycle later. This overrides `ais_n`. The encoder keeps its state and resumes its stream without a gap in the sequence.
- R8: When `lb_line_n` and `lb_term_n` are both low, `loop_err` is high in the following cycle with `line_valid`, `line_pos` and `line_neg` all low. `lb_term_n` alone changes nothing.
- R9: `line_pos` and `line_neg` are never high together. Both are low whenever `line_valid` is low, and a receive input with both rails set is sent as a zero.
- R10: Outside line loopback, `line_valid` is high only in the cycle after a bit transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_p1 | input | 1 | High selects port 1, low selects port 2 |
| p1_valid | input | 1 | Port 1 bit valid |
| p1_data | input | 1 | Port 1 NRZ bit |
| p1_ready | output | 1 | Port 1 can accept a bit |
| p2_valid | input | 1 | Port 2 bit valid |
| p2_data | input | 1 | Port 2 NRZ bit |
| p2_ready | output | 1 | Port 2 can accept a bit |
| ais_n | input | 1 | Alarm fill, active low: data forced to ones |
| lb_line_n | input | 1 | Line loopback, active low |
| lb_term_n | input | 1 | Terminal loopback request, active low; used only for the illegal-combination check |
| rx_valid | input | 1 | Recovered receive symbol valid |
| rx_pos | input | 1 | Recovered receive positive rail |
| rx_neg | input | 1 | Recovered receive negative rail |
| line_valid | output | 1 | A line symbol is present this cycle |
| line_pos | output | 1 | Positive rail pulse |
| line_neg | output | 1 | Negative rail pulse |
| loop_err | output | 1 | Both loopbacks requested together |

## Verification
Every encoded symbol is due exactly one cycle after the edge that accepts the fourth later bit, and a looped-back receive symbol is due one cycle after its own edge. The error flag follows its cause one cycle later in the same way. The bench tags each expected item with the cycle number in which it must be visible. The monitor samples on the falling edge and fails an item that is absent in its cycle, and it also fails any `line_valid` that no item accounts for. The expected stream comes from a sequential reference encoder that rewrites the last four symbols when a zero run completes, and so does not use a look-ahead window.

// File: rtl/hdb3_tx_pkg.sv
package hdb3_tx_pkg;
  // Symbol held in a look-ahead slot before polarity is assigned
  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_BFILL = 2'd2,
    SYM_VIOL  = 2'd3
  } sym_e;

  // One line-side symbol as registered at the output
  typedef struct packed {
    logic vld;
    logic pos;
    logic neg;
  } rail_t;
endpackage

// File: rtl/hdb3_tx_portsel.sv
module hdb3_tx_portsel (
  input  logic sel_p1,
  input  logic enc_en,
  input  logic ais_n,
  input  logic p1_valid,
  input  logic p1_data,
  input  logic p2_valid,
  input  logic p2_data,
  output logic p1_ready,
  output logic p2_ready,
  output logic bit_fire,
  output logic bit_val
);
  logic sel_data;

  assign p1_ready = enc_en & sel_p1;
  assign p2_ready = enc_en & ~sel_p1;
  assign bit_fire = sel_p1 ? (p1_valid & p1_ready) : (p2_valid & p2_ready);
  assign sel_data = sel_p1 ? p1_data : p2_data;
  // alarm fill turns every accepted bit into a mark
  assign bit_val  = ~ais_n | sel_data;
endmodule

// File: rtl/hdb3_tx_window.sv
module hdb3_tx_window
  import hdb3_tx_pkg::*;
#(
  parameter int ZRUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_fire,
  input  logic bit_val,
  output logic emit_valid,
  output logic emit_pos,
  output logic emit_neg
);
  localparam int CW = $clog2(ZRUN + 1);
  localparam logic [CW-1:0] FULL = CW'(ZRUN);

  sym_e win_q [ZRUN];
  sym_e win_d [ZRUN];
  logic [CW-1:0] fill_q, fill_d;
  logic last_pos_q, last_pos_d;  // polarity of the most recent pulse, 1 = positive
  logic odd_q, odd_d;            // parity of non-violation pulses since last V
  sym_e old_sym;
  logic pulse, pol, quiet;

  always_comb begin
    old_sym    = win_q[ZRUN-1];
    emit_valid = bit_fire && (fill_q == FULL);
    pulse      = (old_sym != SYM_SPACE);
    pol        = (old_sym == SYM_VIOL) ? last_pos_q : ~last_pos_q;
    emit_pos   = emit_valid & pulse & pol;
    emit_neg   = emit_valid & pulse & ~pol;

    last_pos_d = last_pos_q;
    odd_d      = odd_q;
    if (emit_valid && pulse) begin
      last_pos_d = pol;
      odd_d      = (old_sym == SYM_VIOL) ? 1'b0 : ~odd_q;
    end

    fill_d = (fill_q == FULL) ? FULL : fill_q + CW'(1);

    win_d[0] = bit_val ? SYM_MARK : SYM_SPACE;
    for (int i = 1; i < ZRUN; i++) win_d[i] = win_q[i-1];

    quiet = (fill_d == FULL);
    for (int i = 0; i < ZRUN; i++) quiet = quiet & (win_d[i] == SYM_SPACE);

    if (quiet) begin
      win_d[0]      = SYM_VIOL;
      win_d[ZRUN-1] = odd_d ? SYM_SPACE : SYM_BFILL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      last_pos_q <= 1'b0;
      odd_q      <= 1'b1;
      for (int i = 0; i < ZRUN; i++) win_q[i] <= SYM_SPACE;
    end else if (bit_fire) begin
      fill_q     <= fill_d;
      last_pos_q <= last_pos_d;
      odd_q      <= odd_d;
      for (int i = 0; i < ZRUN; i++) win_q[i] <= win_d[i];
    end
  end
endmodule

// File: rtl/hdb3_tx_lineout.sv
module hdb3_tx_lineout
  import hdb3_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lb_line_n,
  input  logic lb_term_n,
  input  logic rx_valid,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic enc_valid,
  input  logic enc_pos,
  input  logic enc_neg,
  output logic line_valid,
  output logic line_pos,
  output logic line_neg,
  output logic loop_err
);
  rail_t nxt, cur;
  logic  bad, loop;

  assign bad  = ~lb_line_n & ~lb_term_n;
  assign loop = ~lb_line_n & lb_term_n;

  always_comb begin
    if (bad) begin
      nxt = '0;
    end else if (loop) begin
      nxt.vld = rx_valid;
      nxt.pos = rx_valid & rx_pos & ~rx_neg;
      nxt.neg = rx_valid & rx_neg & ~rx_pos;
    end else begin
      nxt.vld = enc_valid;
      nxt.pos = enc_pos;
      nxt.neg = enc_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      loop_err <= 1'b0;
    end else begin
      cur      <= nxt;
      loop_err <= bad;
    end
  end

  assign line_valid = cur.vld;
  assign line_pos   = cur.pos;
  assign line_neg   = cur.neg;
endmodule

// File: rtl/hdb3_tx_top.sv
module hdb3_tx_top #(
  parameter int ZRUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_p1,
  input  logic p1_valid,
  input  logic p1_data,
  output logic p1_ready,
  input  logic p2_valid,
  input  logic p2_data,
  output logic p2_ready,
  input  logic ais_n,
  input  logic lb_line_n,
  input  logic lb_term_n,
  input  logic rx_valid,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic line_valid,
  output logic line_pos,
  output logic line_neg,
  output logic loop_err
);
  logic bit_fire, bit_val;
  logic enc_valid, enc_pos, enc_neg;

  hdb3_tx_portsel u_sel (
    .sel_p1  (sel_p1),
    .enc_en  (lb_line_n),
    .ais_n   (ais_n),
    .p1_valid(p1_valid),
    .p1_data (p1_data),
    .p2_valid(p2_valid),
    .p2_data (p2_data),
    .p1_ready(p1_ready),
    .p2_ready(p2_ready),
    .bit_fire(bit_fire),
    .bit_val (bit_val)
  );

  hdb3_tx_window #(.ZRUN(ZRUN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_fire  (bit_fire),
    .bit_val   (bit_val),
    .emit_valid(enc_valid),
    .emit_pos  (enc_pos),
    .emit_neg  (enc_neg)
  );

  hdb3_tx_lineout u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .lb_line_n (lb_line_n),
    .lb_term_n (lb_term_n),
    .rx_valid  (rx_valid),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .enc_valid (enc_valid),
    .enc_pos   (enc_pos),
    .enc_neg   (enc_neg),
    .line_valid(line_valid),
    .line_pos  (line_pos),
    .line_neg  (line_neg),
    .loop_err  (loop_err)
  );
endmodule

// File: rtl/hdb3_tx_chk.sv
module hdb3_tx_chk #(
  parameter int ZRUN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sel_p1,
  input logic p1_valid,
  input logic p1_ready,
  input logic p2_valid,
  input logic p2_ready,
  input logic lb_line_n,
  input logic lb_term_n,
  input logic rx_valid,
  input logic rx_pos,
  input logic rx_neg,
  input logic line_valid,
  input logic line_pos,
  input logic line_neg,
  input logic loop_err
);
  localparam int ZW = $clog2(ZRUN + 2);

  logic          lb_q;
  logic [ZW-1:0] zr_q;
  logic [1:0]    hn_q;
  logic          h0_q, h1_q;
  logic          pulse_now, triple;

  assign pulse_now = line_valid & (line_pos ^ line_neg);
  assign triple    = pulse_now && !lb_q && (hn_q == 2'd2) &&
                     (h0_q == line_pos) && (h1_q == line_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q <= 1'b0;
      zr_q <= '0;
      hn_q <= '0;
      h0_q <= 1'b0;
      h1_q <= 1'b0;
    end else begin
      lb_q <= ~lb_line_n;
      if (lb_q) begin
        zr_q <= '0;
        hn_q <= '0;
      end else if (line_valid) begin
        if (pulse_now) begin
          zr_q <= '0;
          h1_q <= h0_q;
          h0_q <= line_pos;
          hn_q <= (hn_q == 2'd2) ? 2'd2 : hn_q + 2'd1;
        end else begin
          zr_q <= (zr_q == ZW'(ZRUN)) ? zr_q : zr_q + ZW'(1);
        end
      end
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_ready && p2_ready)); // R1
  AST_READY_P1: assert property (@(posedge clk) disable iff (!rst_n)
    p1_ready |-> (sel_p1 && lb_line_n)); // R1
  AST_READY_P2: assert property (@(posedge clk) disable iff (!rst_n)
    p2_ready |-> (!sel_p1 && lb_line_n)); // R1
  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    zr_q <= ZW'(ZRUN - 1)); // R5
  AST_NO_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !triple); // R5
  AST_LOOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_line_n && lb_term_n) |=>
      (line_valid == $past(rx_valid)) &&
      (line_pos == $past(rx_valid && rx_pos && !rx_neg)) &&
      (line_neg == $past(rx_valid && rx_neg && !rx_pos))); // R7
  AST_BAD_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_line_n && !lb_term_n) |=> (loop_err && !line_valid && !line_pos && !line_neg)); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_line_n || lb_term_n) |=> !loop_err); // R8
  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg)); // R9
  AST_RAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> (!line_pos && !line_neg)); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_line_n && !(sel_p1 ? p1_valid : p2_valid)) |=> !line_valid); // R10
endmodule

bind hdb3_tx_top hdb3_tx_chk #(.ZRUN(ZRUN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_p1    (sel_p1),
  .p1_valid  (p1_valid),
  .p1_ready  (p1_ready),
  .p2_valid  (p2_valid),
  .p2_ready  (p2_ready),
  .lb_line_n (lb_line_n),
  .lb_term_n (lb_term_n),
  .rx_valid  (rx_valid),
  .rx_pos    (rx_pos),
  .rx_neg    (rx_neg),
  .line_valid(line_valid),
  .line_pos  (line_pos),
  .line_neg  (line_neg),
  .loop_err  (loop_err)
);

// File: tb/sim_hdb3_tx_top.sv
module sim_hdb3_tx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_p1 = 1'b1;
  logic p1_valid = 1'b0, p1_data = 1'b0, p2_valid = 1'b0, p2_data = 1'b0;
  logic ais_n = 1'b1, lb_line_n = 1'b1, lb_term_n = 1'b1;
  logic rx_valid = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic p1_ready, p2_ready, line_valid, line_pos, line_neg, loop_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference encoder state
  bit sp[$];
  bit sn[$];
  bit m_last = 1'b0;
  bit m_par = 1'b1;
  int m_zeros = 0;

  // scoreboard
  bit [1:0] eq[$];
  int       dq[$];
  string    tq[$];

  bit junk = 1'b0;
  logic [15:0] lf = 16'hACE1;

  hdb3_tx_top u0 (
    .clk(clk), .rst_n(rst_n), .sel_p1(sel_p1),
    .p1_valid(p1_valid), .p1_data(p1_data), .p1_ready(p1_ready),
    .p2_valid(p2_valid), .p2_data(p2_data), .p2_ready(p2_ready),
    .ais_n(ais_n), .lb_line_n(lb_line_n), .lb_term_n(lb_term_n),
    .rx_valid(rx_valid), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .line_valid(line_valid), .line_pos(line_pos), .line_neg(line_neg),
    .loop_err(loop_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic void push_exp(input bit p, input bit n, input string tag);
    eq.push_back({p, n});
    dq.push_back(cyc + 1);
    tq.push_back(tag);
  endfunction

  // sequential reference: rewrites the last four symbols when a zero run completes
  function automatic void model_add(input bit b, input string tag);
    int n;
    bit bp;
    if (b) begin
      bp = !m_last;
      sp.push_back(bp);
      sn.push_back(!bp);
      m_last = bp;
      m_par = !m_par;
      m_zeros = 0;
    end else begin
      sp.push_back(1'b0);
      sn.push_back(1'b0);
      m_zeros++;
      if (m_zeros == 4) begin
        n = sp.size();
        if (m_par) begin
          sp[n-1] = m_last;
          sn[n-1] = !m_last;
        end else begin
          bp = !m_last;
          sp[n-4] = bp; sn[n-4] = !bp;
          sp[n-1] = bp; sn[n-1] = !bp;
          m_last = bp;
        end
        m_par = 1'b0;
        m_zeros = 0;
      end
    end
    if (sp.size() >= 5) begin
      n = sp.size() - 5;
      push_exp(sp[n], sn[n], tag);
    end
  endfunction

  task automatic send_bit(input bit port1, input bit b, input string tag);
    @(negedge clk);
    sel_p1 = port1;
    if (port1) begin
      p1_valid = 1'b1; p1_data = b;
      p2_valid = junk; p2_data = lf[0];
    end else begin
      p2_valid = 1'b1; p2_data = b;
      p1_valid = junk; p1_data = lf[0];
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    model_add(ais_n ? b : 1'b1, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p1_valid = 1'b0;
      p2_valid = 1'b0;
    end
  endtask

  task automatic send_stream(input bit port1, input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      send_bit(port1, lf[3], tag);
      if (gap != 0 && (i % gap) == gap - 1) idle(1);
    end
  endtask

  task automatic loop_bit(input bit p, input bit n, input bit v);
    @(negedge clk);
    lb_line_n = 1'b0;
    rx_valid = v; rx_pos = p; rx_neg = n;
    p1_valid = 1'b1; p1_data = 1'b1;
    p2_valid = 1'b1; p2_data = 1'b1;
    if (v) push_exp(p & ~n, n & ~p, "R7");
    #1;
    chk(p1_ready == 1'b0 && p2_ready == 1'b0, "R7", "ready during loopback",
        {p1_ready, p2_ready}, 0);
  endtask

  // monitor: each expected item must be visible exactly in its due cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (eq.size() > 0 && dq[0] == cyc) begin
        chk(line_valid && ({line_pos, line_neg} == eq[0]), tq[0], "line symbol",
            {line_valid, line_pos, line_neg}, {1'b1, eq[0]});
        void'(eq.pop_front());
        void'(dq.pop_front());
        void'(tq.pop_front());
      end else if (line_valid) begin
        chk(1'b0, "R10", "unexpected line_valid", {line_pos, line_neg}, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_valid == 1'b0 && loop_err == 1'b0, "R9", "reset outputs",
        {line_valid, loop_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p1_ready == 1'b1 && p2_ready == 1'b0, "R1", "ready with port 1 selected",
        {p1_ready, p2_ready}, 2);

    // R3: first pulses after reset; R2: no output while the window fills
    send_bit(1'b1, 1'b1, "R3");
    send_bit(1'b1, 1'b0, "R3");
    send_bit(1'b1, 1'b1, "R3");
    send_bit(1'b1, 1'b0, "R3");
    @(negedge clk);
    p1_valid = 1'b0;
    chk(line_valid == 1'b0, "R2", "no symbol before window is full", line_valid, 0);

    // R4: 000V after odd count, B00V after even count, back-to-back fills
    foreach (sp[i]) begin end
    begin
      bit pat [19] = '{0,0,0, 1,0,0,0,0, 1,1,0,0,0,0, 0,0,0,0, 1};
      for (int i = 0; i < 19; i++) send_bit(1'b1, pat[i], "R4");
    end

    // R1: long stream on port 1 with activity on port 2
    junk = 1'b1;
    send_stream(1'b1, 60, 0, "R1");
    idle(3);
    sel_p1 = 1'b0;
    #1;
    chk(p1_ready == 1'b0 && p2_ready == 1'b1, "R1", "ready with port 2 selected",
        {p1_ready, p2_ready}, 1);
    // R10: gaps between transfers on port 2
    send_stream(1'b0, 40, 5, "R10");
    idle(1);

    // R6: alarm fill with zero data
    ais_n = 1'b0;
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0, "R6");
    idle(1);
    ais_n = 1'b1;

    // R8: terminal loopback alone leaves encoding unchanged
    lb_term_n = 1'b0;
    send_stream(1'b0, 10, 0, "R8");
    idle(1);
    lb_term_n = 1'b1;

    // R7: line loopback overrides alarm fill; R9: rail collision blanked
    ais_n = 1'b0;
    loop_bit(1'b1, 1'b0, 1'b1);
    loop_bit(1'b0, 1'b1, 1'b1);
    loop_bit(1'b0, 1'b0, 1'b1);
    loop_bit(1'b1, 1'b1, 1'b1);
    loop_bit(1'b1, 1'b0, 1'b0);
    loop_bit(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    lb_line_n = 1'b1; rx_valid = 1'b0; p1_valid = 1'b0; p2_valid = 1'b0;
    ais_n = 1'b1;

    // R7: encoder resumes its stream after loopback
    send_stream(1'b0, 12, 0, "R7");
    idle(1);

    // R8: both loopbacks together
    @(negedge clk);
    lb_line_n = 1'b0; lb_term_n = 1'b0;
    rx_valid = 1'b1; rx_pos = 1'b1; rx_neg = 1'b0;
    p2_valid = 1'b1;
    #1;
    chk(p1_ready == 1'b0 && p2_ready == 1'b0, "R8", "ready in illegal state",
        {p1_ready, p2_ready}, 0);
    @(negedge clk);
    chk(loop_err == 1'b1, "R8", "loop_err raised", loop_err, 1);
    chk(line_valid == 1'b0 && line_pos == 1'b0 && line_neg == 1'b0, "R8",
        "line silent in illegal state", {line_valid, line_pos, line_neg}, 0);
    lb_line_n = 1'b1; lb_term_n = 1'b1; rx_valid = 1'b0; p2_valid = 1'b0;
    @(negedge clk);
    chk(loop_err == 1'b0, "R8", "loop_err cleared", loop_err, 0);

    send_stream(1'b1, 16, 3, "R5");
    idle(6);
    chk(eq.size() == 0, "R2", "expected symbols left over", eq.size(), 0);
    finish_run();
  end
endmodule